// File: doc/BRIEF.md
# Operand Bypass and Hazard Stall Unit

This block resolves data hazards for the operand-read stage of a five-stage in-order pipeline. The stages, in order, are fetch, operand read, ALU, memory access and write-back. The instruction in the operand-read stage has two source register fields. For each one, the block chooses where the operand value comes from. It can come from the register file. It can also be taken from the destination result held in the ALU, memory or write-back stage. When several stages write the same register, the youngest producer wins.

The block keeps a small destination-tag record for each of the three downstream stages. Each record holds a valid bit, a write-enable, a load flag and a 5-bit destination index. A load's data cannot be taken from the ALU stage. When the youngest producer of a needed register is a load that is not yet forwardable, the block raises a stall. On a stall the program counter and the fetch and operand-read registers hold their values, and the block shifts a bubble into its ALU-stage record. Register 31 is hard-wired to zero. A source that names it always reads from the register file, and a write to it is never forwarded.

Top module: `hz_bypass_unit`

## Requirements
- R1: Each select output is a 2-bit code: 00 register file, 01 ALU stage, 10 memory stage, 11 write-back stage. A select is 00 when no downstream stage matches its source field.
- R2: An instruction that writes register X selects 01 for a source X on the cycle after it was accepted in the operand stage, provided it is not a load. Being accepted means it was valid and no stall was raised.
- R3: Such a producer is selected with 10 for a matching source on the second cycle after it was accepted.
- R4: Such a producer is selected with 11 for a matching source on the third cycle after it was accepted.
- R5: When several downstream stages match the same source, the youngest stage is chosen. The ALU stage comes first, then memory, then write-back.
- R6: A source field of 31 always gives 00 and never causes a stall. A producer whose destination is 31 never matches.
- R7: A downstream stage matches only if it is valid and its write-enable is set. An instruction sent down with write-enable clear is never forwarded.
- R8: If the youngest matching stage for a used source holds a load in the ALU stage, `stall` is 1. With the default parameter, a load in the memory stage is forwarded with 10 and does not stall.
- R9: After a stall cycle, the ALU stage holds a bubble: `alu_bubble` is 1 and no select is 01. The older stages still advance, so a stalled load is then selected with 10.
- R10: When `rf_rb_used` is 0, `sel_b` is 00 and the second source field cannot cause a stall.
- R11: When `rf_valid` is 0, both selects are 00 and `stall` is 0.
- R12: After reset all downstream records are empty: selects are 00, `stall` is 0 and `alu_bubble` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_valid | input | 1 | Operand stage holds a real instruction |
| rf_ra | input | 5 | First source register field |
| rf_rb | input | 5 | Second source register field |
| rf_rb_used | input | 1 | Instruction reads the second source |
| rf_dst | input | 5 | Destination register of the operand-stage instruction |
| rf_we | input | 1 | Operand-stage instruction writes its destination |
| rf_is_load | input | 1 | Operand-stage instruction is a load |
| sel_a | output | 2 | Source select for the first operand |
| sel_b | output | 2 | Source select for the second operand |
| stall | output | 1 | Hold fetch and operand stage, inject bubble |
| alu_bubble | output | 1 | ALU-stage record holds an injected bubble |

## Verification
Directed sequences place one producer at a time at distances of one, two and three instructions. These show that each stage's code is reached on the right cycle. Stacked producers of the same register separate youngest-first priority from any other order. Register-31 sources and destinations, write-disabled producers and unused second operands confirm that a field which looks like a match is ignored. A load followed directly by its consumer shows the stall, then the bubble, then forwarding from the memory stage. Seeded random streams drawn from a narrow register range produce many overlapping hazards, and the bench checks each one against its own model of the stage records.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int REG_W = 5;

    typedef logic [REG_W-1:0] reg_idx_t;

    localparam reg_idx_t ZERO_REG = '1;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_ALU = 2'b01,
        SRC_MEM = 2'b10,
        SRC_WB  = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic     valid;
        logic     we;
        logic     is_load;
        reg_idx_t dst;
    } stage_tag_t;

    localparam stage_tag_t EMPTY_TAG = '0;

    function automatic logic tag_hits(stage_tag_t t, reg_idx_t r);
        return t.valid && t.we && (t.dst != ZERO_REG) && (t.dst == r);
    endfunction

endpackage

// File: rtl/hz_stage_pipe.sv
module hz_stage_pipe
    import hz_pkg::*;
#(
    parameter int NUM_STAGES = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        stall,
    input  stage_tag_t                  rf_tag,
    output stage_tag_t [NUM_STAGES-1:0] tags,
    output logic                        bubble
);

    // Youngest record: new instruction, or injected bubble on a stall
    always_ff @(posedge clk) begin
        if (rst) begin
            tags[0] <= EMPTY_TAG;
            bubble  <= 1'b0;
        end else begin
            tags[0] <= stall ? EMPTY_TAG : rf_tag;
            bubble  <= stall;
        end
    end

    // Older records always advance
    for (genvar s = 1; s < NUM_STAGES; s++) begin : g_shift
        always_ff @(posedge clk) begin
            if (rst) tags[s] <= EMPTY_TAG;
            else     tags[s] <= tags[s-1];
        end
    end

endmodule

// File: rtl/hz_operand_sel.sv
module hz_operand_sel
    import hz_pkg::*;
#(
    parameter int NUM_STAGES    = 3,
    parameter int LOAD_READY_IX = 1
) (
    input  reg_idx_t                    src,
    input  logic                        used,
    input  stage_tag_t [NUM_STAGES-1:0] tags,
    output src_sel_e                    sel,
    output logic                        wait_req
);

    localparam int SEL_W = $bits(src_sel_e);

    logic [NUM_STAGES-1:0] hit;

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_cmp
        assign hit[s] = used && tag_hits(tags[s], src);
    end

    // Scan from oldest to youngest so the youngest hit is written last
    always_comb begin
        sel      = SRC_RF;
        wait_req = 1'b0;
        for (int s = NUM_STAGES - 1; s >= 0; s--) begin
            if (hit[s]) begin
                sel      = src_sel_e'(SEL_W'(s + 1));
                wait_req = tags[s].is_load && (s < LOAD_READY_IX);
            end
        end
    end

endmodule

// File: rtl/hz_bypass_unit.sv
module hz_bypass_unit
    import hz_pkg::*;
#(
    parameter int NUM_STAGES   = 3,
    parameter bit LOAD_FWD_MEM = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rf_valid,
    input  logic [4:0] rf_ra,
    input  logic [4:0] rf_rb,
    input  logic       rf_rb_used,
    input  logic [4:0] rf_dst,
    input  logic       rf_we,
    input  logic       rf_is_load,
    output logic [1:0] sel_a,
    output logic [1:0] sel_b,
    output logic       stall,
    output logic       alu_bubble
);

    localparam int NUM_OPS       = 2;
    localparam int LOAD_READY_IX = LOAD_FWD_MEM ? 1 : 2;

    stage_tag_t                  rf_tag;
    stage_tag_t [NUM_STAGES-1:0] tags;
    reg_idx_t   [NUM_OPS-1:0]    op_src;
    logic       [NUM_OPS-1:0]    op_used;
    src_sel_e   [NUM_OPS-1:0]    op_sel;
    logic       [NUM_OPS-1:0]    op_wait;

    assign rf_tag = '{valid: rf_valid, we: rf_we, is_load: rf_is_load, dst: rf_dst};

    assign op_src[0]  = rf_ra;
    assign op_src[1]  = rf_rb;
    assign op_used[0] = rf_valid;
    assign op_used[1] = rf_valid && rf_rb_used;

    hz_stage_pipe #(.NUM_STAGES(NUM_STAGES)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .stall  (stall),
        .rf_tag (rf_tag),
        .tags   (tags),
        .bubble (alu_bubble)
    );

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
        hz_operand_sel #(
            .NUM_STAGES    (NUM_STAGES),
            .LOAD_READY_IX (LOAD_READY_IX)
        ) u_sel (
            .src      (op_src[k]),
            .used     (op_used[k]),
            .tags     (tags),
            .sel      (op_sel[k]),
            .wait_req (op_wait[k])
        );
    end

    assign sel_a = op_sel[0];
    assign sel_b = op_sel[1];
    assign stall = |op_wait;

endmodule

// File: rtl/hz_bypass_chk.sv
module hz_bypass_chk (
    input logic       clk,
    input logic       rst,
    input logic       rf_valid,
    input logic [4:0] rf_ra,
    input logic [4:0] rf_rb,
    input logic       rf_rb_used,
    input logic [1:0] sel_a,
    input logic [1:0] sel_b,
    input logic       stall,
    input logic       alu_bubble
);

    // R6
    zero_reg_src_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_ra == 5'd31) |-> (sel_a == 2'b00));

    // R9
    bubble_after_stall_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> alu_bubble);

    // R9
    bubble_no_alu_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        alu_bubble |-> (sel_a != 2'b01 && sel_b != 2'b01));

    // R10
    unused_rb_chk: assert property (@(posedge clk) disable iff (rst)
        (!rf_rb_used) |-> (sel_b == 2'b00));

    // R11
    idle_rf_chk: assert property (@(posedge clk) disable iff (rst)
        (!rf_valid) |-> (sel_a == 2'b00 && sel_b == 2'b00 && !stall));

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!alu_bubble && !stall));

endmodule

bind hz_bypass_unit hz_bypass_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rf_valid   (rf_valid),
    .rf_ra      (rf_ra),
    .rf_rb      (rf_rb),
    .rf_rb_used (rf_rb_used),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .stall      (stall),
    .alu_bubble (alu_bubble)
);

// File: tb/hz_bypass_unit_test.sv
module hz_bypass_unit_test;

    localparam bit LFM = 1'b1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rf_valid = 0, rf_rb_used = 0, rf_we = 0, rf_is_load = 0;
    logic [4:0] rf_ra = 0, rf_rb = 0, rf_dst = 0;
    logic [1:0] sel_a, sel_b;
    logic       stall, alu_bubble;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model of the downstream records: index 0 ALU, 1 MEM, 2 WB
    logic       m_v [3];
    logic       m_we[3];
    logic       m_ld[3];
    logic [4:0] m_d [3];
    logic       m_bub;

    always #10 clk = ~clk;

    hz_bypass_unit #(.LOAD_FWD_MEM(LFM)) uut (
        .clk(clk), .rst(rst), .rf_valid(rf_valid), .rf_ra(rf_ra), .rf_rb(rf_rb),
        .rf_rb_used(rf_rb_used), .rf_dst(rf_dst), .rf_we(rf_we), .rf_is_load(rf_is_load),
        .sel_a(sel_a), .sel_b(sel_b), .stall(stall), .alu_bubble(alu_bubble)
    );

    // returns {wait, sel}
    function automatic logic [2:0] exp_sel(logic [4:0] src, logic used);
        logic [2:0] r = 3'b000;
        if (!used || src == 5'd31) return r;
        for (int s = 0; s < 3; s++) begin
            if (m_v[s] && m_we[s] && m_d[s] == src && m_d[s] != 5'd31) begin
                r[1:0] = 2'(s + 1);
                r[2]   = m_ld[s] && (s == 0 || (s == 1 && !LFM));
                return r;
            end
        end
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < 3; s++) begin
            m_v[s] = 0; m_we[s] = 0; m_ld[s] = 0; m_d[s] = 0;
        end
        m_bub = 0;
    endtask

    // one cycle: drive at negedge, check, advance model at posedge
    task automatic cyc(string req, logic v, logic [4:0] a, logic [4:0] b,
                       logic bu, logic [4:0] d, logic we, logic ld);
        logic [2:0] ea, eb;
        logic       es;
        rf_valid = v; rf_ra = a; rf_rb = b; rf_rb_used = bu;
        rf_dst = d; rf_we = we; rf_is_load = ld;
        #2;
        ea = exp_sel(a, v);
        eb = exp_sel(b, v && bu);
        es = ea[2] | eb[2];
        chk({req, " sel_a"}, 32'(sel_a), 32'(ea[1:0]));
        chk({req, " sel_b"}, 32'(sel_b), 32'(eb[1:0]));
        chk({req, " stall"}, 32'(stall), 32'(es));
        chk({req, " alu_bubble"}, 32'(alu_bubble), 32'(m_bub));
        @(posedge clk);
        for (int s = 2; s > 0; s--) begin
            m_v[s] = m_v[s-1]; m_we[s] = m_we[s-1]; m_ld[s] = m_ld[s-1]; m_d[s] = m_d[s-1];
        end
        if (es) begin m_v[0] = 0; m_we[0] = 0; m_ld[0] = 0; m_d[0] = 0; end
        else    begin m_v[0] = v; m_we[0] = we; m_ld[0] = ld; m_d[0] = d; end
        m_bub = es;
        @(negedge clk);
    endtask

    task automatic nop();
        cyc("R11", 0, 0, 0, 0, 0, 0, 0);
    endtask

    function automatic logic [4:0] pick_reg();
        int r = $urandom % 8;
        return (r < 4) ? 5'(r) : 5'(28 + r - 4);
    endfunction

    initial begin
        #(20ns * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R12: reset state
        chk("R12 alu_bubble", 32'(alu_bubble), 0);
        chk("R12 stall", 32'(stall), 0);
        cyc("R12", 1, 5'd1, 5'd2, 1, 5'd3, 1, 0);

        // R2 R3 R4: producer then consumers at distance 1,2,3
        nop(); nop(); nop();
        cyc("R2", 1, 5'd0, 5'd0, 0, 5'd4, 1, 0);
        cyc("R2", 1, 5'd4, 5'd9, 1, 5'd9, 0, 0);
        cyc("R3", 1, 5'd9, 5'd4, 1, 5'd10, 0, 0);
        cyc("R4", 1, 5'd4, 5'd4, 1, 5'd11, 0, 0);
        cyc("R1", 1, 5'd4, 5'd4, 1, 5'd11, 0, 0);

        // R5: three producers of the same register
        cyc("R5", 1, 0, 0, 0, 5'd6, 1, 0);
        cyc("R5", 1, 0, 0, 0, 5'd6, 1, 0);
        cyc("R5", 1, 0, 0, 0, 5'd6, 1, 0);
        cyc("R5", 1, 5'd6, 5'd6, 1, 5'd7, 1, 0);

        // R6: register 31 source and destination
        cyc("R6", 1, 0, 0, 0, 5'd31, 1, 1);
        cyc("R6", 1, 5'd31, 5'd31, 1, 5'd12, 1, 0);
        // R7: write-enable clear never forwarded
        cyc("R7", 1, 0, 0, 0, 5'd13, 0, 0);
        cyc("R7", 1, 5'd13, 5'd13, 1, 5'd14, 0, 0);

        // R8 R9: load then dependent consumer
        nop(); nop(); nop();
        cyc("R8", 1, 0, 0, 0, 5'd2, 1, 1);
        cyc("R8", 1, 5'd2, 5'd0, 0, 5'd3, 1, 0);
        cyc("R9", 1, 5'd2, 5'd0, 0, 5'd3, 1, 0);
        // R10: unused rb with load in ALU
        cyc("R10", 1, 0, 0, 0, 5'd5, 1, 1);
        cyc("R10", 1, 5'd1, 5'd5, 0, 5'd8, 1, 0);
        // R8 on rb
        cyc("R8", 1, 0, 0, 0, 5'd5, 1, 1);
        cyc("R8", 1, 5'd1, 5'd5, 1, 5'd8, 1, 0);
        cyc("R9", 1, 5'd1, 5'd5, 1, 5'd8, 1, 0);
        // R11
        nop();

        // random stream; hold the operand stage during a stall
        begin
            logic v = 0, bu = 0, we = 0, ld = 0;
            logic [4:0] a = 0, b = 0, d = 0;
            for (int i = 0; i < 600; i++) begin
                if (!(m_v[0] === 1'bx) && !(exp_sel(a, v)[2] | exp_sel(b, v && bu)[2]) || i == 0) begin
                    v  = ($urandom % 8) != 0;
                    a  = pick_reg(); b = pick_reg(); d = pick_reg();
                    bu = $urandom % 2; we = ($urandom % 4) != 0; ld = ($urandom % 3) == 0;
                end
                cyc("R5 random", v, a, b, bu, d, we, ld);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule